// File: doc/BRIEF.md
# Set-Associative Cache Line Engine with Half-Line Dirty Tracking

This block manages the lines of a write-back-capable, set-associative data cache. Every line holds eight 32-bit words, one valid bit, a dirty bit for each four-word half and the physical tag that the line was filled from. A CPU load/store request arrives on a valid/ready handshake, together with a per-access cacheable flag and a write-through flag. It also carries the index of the way that an external replacement policy chose as victim.

A load hit returns the stored word on the next cycle. A load miss to cacheable space first evicts the victim. Only the halves marked dirty are copied back to memory, and their addresses are built from the stored tag. Next the engine fetches the whole new line into the victim way, and then returns the requested word. A cacheable store hit updates the line. In write-back mode it marks the affected half dirty. In write-through mode it also forwards the word to memory. Store misses and uncacheable accesses bypass the line storage and become single-word memory transfers. While any memory sequence runs, the CPU port is stalled.

Top module: `cache_line_engine`

## Requirements
- R1: After reset, req_ready is 1, busy is 0, mem_valid is 0, rsp_valid is 0, and every line is invalid, so the first cacheable load to any set misses.
- R2: A cacheable load that hits raises rsp_valid on the cycle after acceptance, with the stored word on rsp_rdata, and causes no memory transfer.
- R3: On eviction of a valid victim, a half is written back only if its dirty bit is set. Half 0 is words 0..3 (word address bit 2 = 0) and half 1 is words 4..7 (bit 2 = 1). Words go out in ascending order to address {stored tag, set index, word}.
- R4: A cacheable store hit with req_wthru = 0 updates the addressed word, causes no memory transfer, and marks the half that holds the word dirty.
- R5: A cacheable store hit with req_wthru = 1 updates the addressed word and makes exactly one memory write of that word. No dirty bit is set, so a later eviction of that half writes nothing.
- R6: A cacheable load miss reads words 0 to 7 in order at {request tag, set index, word} into the victim way. rsp_valid rises with the requested word on the cycle after the last word arrives, and later loads to that line hit.
- R7: An uncacheable access is one memory transfer at req_addr. A load returns the memory word even if the address is cached, and the cached copy is left unchanged.
- R8: A cacheable store miss is one memory write of the word and allocates no line.
- R9: busy is high and req_ready low while a memory sequence runs. A memory request holds mem_addr, mem_write and mem_wdata steady until mem_ready is seen.
- R10: A victim that is invalid or has both dirty bits clear is replaced with no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Engine accepts a request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address: bits 2:0 word, then set index, then tag |
| req_wdata | input | DATA_W | Store data |
| req_cacheable | input | 1 | Access may use the cache |
| req_wthru | input | 1 | Store uses write-through policy |
| victim_way | input | WAY_W | Way replaced on a load miss |
| rsp_valid | output | 1 | Load data valid (one cycle) |
| rsp_rdata | output | DATA_W | Load data |
| busy | output | 1 | Memory sequence in progress |
| mem_valid | output | 1 | Memory word request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory completes the current word |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The bench builds the engine with 4 ways, 8 sets and a 12-bit word address, which leaves a 6-bit tag. With so few sets, two tags can be made to collide in one set within a handful of requests. That gives evictions with no dirty half, one dirty half or both dirty halves, and the victim way can point at a line that was never filled. The bench memory raises mem_ready only on every other cycle, so each burst also exercises the hold rule.

// File: rtl/cle_pkg.sv
package cle_pkg;
   localparam int LINE_WORDS = 8;
   localparam int OFF_W      = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_EVICT,
      ST_FILL,
      ST_PASS_WR,
      ST_PASS_RD
   } cle_state_t;
endpackage

// File: rtl/cle_tag_store.sv
module cle_tag_store #(
   parameter int WAYS  = 4,
   parameter int SETS  = 8,
   parameter int TAG_W = 6,
   localparam int WAY_W = $clog2(WAYS),
   localparam int SET_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_i,
   input  logic [TAG_W-1:0] look_tag,
   output logic [WAYS-1:0]  hit_vec,
   input  logic [WAY_W-1:0] sel_way,
   output logic             sel_valid,
   output logic [1:0]       sel_dirty,
   output logic [TAG_W-1:0] sel_tag,
   input  logic [WAY_W-1:0] upd_way,
   input  logic             drop_en,
   input  logic             fill_en,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic             mark_en,
   input  logic             mark_half
);
   logic [WAYS-1:0]  way_valid;
   logic [1:0]       way_dirty [WAYS];
   logic [TAG_W-1:0] way_tag   [WAYS];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [SETS-1:0]  valid_q;
      logic [1:0]       dirty_q [SETS];
      logic [TAG_W-1:0] tag_q   [SETS];
      logic             mine;

      assign mine         = (upd_way == WAY_W'(w));
      assign way_valid[w] = valid_q[set_i];
      assign way_dirty[w] = dirty_q[set_i];
      assign way_tag[w]   = tag_q[set_i];
      assign hit_vec[w]   = valid_q[set_i] && (tag_q[set_i] == look_tag);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q <= '0;
            for (int s = 0; s < SETS; s++) begin
               dirty_q[s] <= '0;
               tag_q[s]   <= '0;
            end
         end else if (mine) begin
            if (drop_en) begin
               valid_q[set_i] <= 1'b0;
               dirty_q[set_i] <= 2'b00;
            end else if (fill_en) begin
               valid_q[set_i] <= 1'b1;
               dirty_q[set_i] <= 2'b00;
               tag_q[set_i]   <= fill_tag;
            end else if (mark_en) begin
               dirty_q[set_i][mark_half] <= 1'b1;
            end
         end
      end
   end

   assign sel_valid = way_valid[sel_way];
   assign sel_dirty = way_dirty[sel_way];
   assign sel_tag   = way_tag[sel_way];
endmodule

// File: rtl/cle_data_store.sv
module cle_data_store #(
   parameter int WAYS   = 4,
   parameter int SETS   = 8,
   parameter int DATA_W = 32,
   localparam int WAY_W = $clog2(WAYS),
   localparam int SET_W = $clog2(SETS),
   localparam int DEPTH = WAYS * SETS * cle_pkg::LINE_WORDS,
   localparam int IDX_W = WAY_W + SET_W + cle_pkg::OFF_W
) (
   input  logic                      clk,
   input  logic [SET_W-1:0]          set_i,
   input  logic [WAY_W-1:0]          rd_way,
   input  logic [cle_pkg::OFF_W-1:0] rd_word,
   output logic [DATA_W-1:0]         rd_data,
   input  logic                      wr_en,
   input  logic [WAY_W-1:0]          wr_way,
   input  logic [cle_pkg::OFF_W-1:0] wr_word,
   input  logic [DATA_W-1:0]         wr_data
);
   logic [DATA_W-1:0] words_q [DEPTH];
   logic [IDX_W-1:0]  rd_idx, wr_idx;

   assign rd_idx  = {rd_way, set_i, rd_word};
   assign wr_idx  = {wr_way, set_i, wr_word};
   assign rd_data = words_q[rd_idx];

   always_ff @(posedge clk) begin
      if (wr_en) words_q[wr_idx] <= wr_data;
   end
endmodule

// File: rtl/cache_line_engine.sv
module cache_line_engine
   import cle_pkg::*;
#(
   parameter int WAYS   = 4,
   parameter int SETS   = 8,
   parameter int ADDR_W = 20,
   parameter int DATA_W = 32,
   localparam int WAY_W = $clog2(WAYS),
   localparam int SET_W = $clog2(SETS),
   localparam int TAG_W = ADDR_W - SET_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_cacheable,
   input  logic              req_wthru,
   input  logic [WAY_W-1:0]  victim_way,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              busy,
   output logic              mem_valid,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata
);
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (SETS < 2 || (1 << SET_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for the geometry");
   end

   cle_state_t        state_q;
   logic [ADDR_W-1:0] r_addr;
   logic [DATA_W-1:0] r_wdata;
   logic [WAY_W-1:0]  r_way;
   logic [TAG_W-1:0]  r_vtag;
   logic [1:0]        r_vdirty;
   logic [OFF_W-1:0]  cnt_q;
   logic [DATA_W-1:0] r_hold;

   logic              idle, accept, hs, hit;
   logic [ADDR_W-1:0] cur_addr;
   logic [SET_W-1:0]  cur_set;
   logic [TAG_W-1:0]  cur_tag;
   logic [OFF_W-1:0]  cur_off;
   logic [WAYS-1:0]   hit_vec;
   logic [WAY_W-1:0]  hit_way;
   logic              sel_valid;
   logic [1:0]        sel_dirty, vic_dirty;
   logic [TAG_W-1:0]  sel_tag;
   logic              drop_en, fill_en, mark_en;
   logic [WAY_W-1:0]  upd_way, rd_way, wr_way;
   logic [OFF_W-1:0]  rd_word, wr_word;
   logic [DATA_W-1:0] rd_data, wr_data;
   logic              wr_en;

   assign idle      = (state_q == ST_IDLE);
   assign req_ready = idle;
   assign busy      = !idle;
   assign accept    = idle && req_valid;
   assign hs        = mem_valid && mem_ready;
   assign cur_addr  = idle ? req_addr : r_addr;
   assign cur_off   = cur_addr[OFF_W-1:0];
   assign cur_set   = cur_addr[OFF_W +: SET_W];
   assign cur_tag   = cur_addr[ADDR_W-1 -: TAG_W];
   assign hit       = |hit_vec;
   assign vic_dirty = sel_valid ? sel_dirty : 2'b00;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
   end

   cle_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .set_i(cur_set), .look_tag(cur_tag),
      .hit_vec(hit_vec), .sel_way(victim_way), .sel_valid(sel_valid),
      .sel_dirty(sel_dirty), .sel_tag(sel_tag), .upd_way(upd_way),
      .drop_en(drop_en), .fill_en(fill_en), .fill_tag(cur_tag),
      .mark_en(mark_en), .mark_half(cur_off[OFF_W-1])
   );

   cle_data_store #(.WAYS(WAYS), .SETS(SETS), .DATA_W(DATA_W)) u_data (
      .clk(clk), .set_i(cur_set), .rd_way(rd_way), .rd_word(rd_word),
      .rd_data(rd_data), .wr_en(wr_en), .wr_way(wr_way),
      .wr_word(wr_word), .wr_data(wr_data)
   );

   // Line-state and word-storage controls
   always_comb begin
      drop_en = 1'b0;
      fill_en = 1'b0;
      mark_en = 1'b0;
      wr_en   = 1'b0;
      upd_way = r_way;
      rd_way  = idle ? hit_way : r_way;
      rd_word = idle ? cur_off : cnt_q;
      wr_way  = r_way;
      wr_word = cnt_q;
      wr_data = mem_rdata;
      if (accept && req_cacheable) begin
         if (req_write && hit) begin
            wr_en   = 1'b1;
            wr_way  = hit_way;
            wr_word = cur_off;
            wr_data = req_wdata;
            upd_way = hit_way;
            mark_en = !req_wthru;
         end else if (!req_write && !hit) begin
            upd_way = victim_way;
            drop_en = 1'b1;
         end
      end
      if (state_q == ST_FILL && hs) begin
         wr_en   = 1'b1;
         fill_en = (cnt_q == OFF_W'(LINE_WORDS - 1));
      end
   end

   // Memory port
   always_comb begin
      mem_valid = 1'b0;
      mem_write = 1'b0;
      mem_addr  = r_addr;
      mem_wdata = r_wdata;
      unique case (state_q)
         ST_EVICT: begin
            mem_valid = 1'b1;
            mem_write = 1'b1;
            mem_addr  = {r_vtag, r_addr[OFF_W +: SET_W], cnt_q};
            mem_wdata = rd_data;
         end
         ST_FILL: begin
            mem_valid = 1'b1;
            mem_addr  = {r_addr[ADDR_W-1:OFF_W], cnt_q};
         end
         ST_PASS_WR: begin
            mem_valid = 1'b1;
            mem_write = 1'b1;
         end
         ST_PASS_RD: mem_valid = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         r_addr    <= '0;
         r_wdata   <= '0;
         r_way     <= '0;
         r_vtag    <= '0;
         r_vdirty  <= '0;
         cnt_q     <= '0;
         r_hold    <= '0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               r_addr   <= req_addr;
               r_wdata  <= req_wdata;
               r_way    <= victim_way;
               r_vtag   <= sel_tag;
               r_vdirty <= vic_dirty;
               if (!req_cacheable) begin
                  state_q <= req_write ? ST_PASS_WR : ST_PASS_RD;
               end else if (req_write) begin
                  if (!hit || req_wthru) state_q <= ST_PASS_WR;
               end else if (hit) begin
                  rsp_valid <= 1'b1;
                  rsp_rdata <= rd_data;
               end else if (vic_dirty != 2'b00) begin
                  state_q <= ST_EVICT;
                  cnt_q   <= vic_dirty[0] ? OFF_W'(0) : OFF_W'(LINE_WORDS / 2);
               end else begin
                  state_q <= ST_FILL;
                  cnt_q   <= '0;
               end
            end
            ST_EVICT: if (hs) begin
               if (cnt_q == OFF_W'(LINE_WORDS / 2 - 1) && r_vdirty[1]) begin
                  cnt_q <= cnt_q + 1'b1;
               end else if (cnt_q[OFF_W-2:0] == '1) begin
                  state_q <= ST_FILL;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_FILL: if (hs) begin
               if (cnt_q == r_addr[OFF_W-1:0]) r_hold <= mem_rdata;
               if (cnt_q == OFF_W'(LINE_WORDS - 1)) begin
                  state_q   <= ST_IDLE;
                  rsp_valid <= 1'b1;
                  rsp_rdata <= (r_addr[OFF_W-1:0] == cnt_q) ? mem_rdata : r_hold;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_PASS_WR: if (hs) state_q <= ST_IDLE;
            ST_PASS_RD: if (hs) begin
               state_q   <= ST_IDLE;
               rsp_valid <= 1'b1;
               rsp_rdata <= mem_rdata;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cle_checker.sv
module cle_checker #(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              rsp_valid,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic              mem_write,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              evict_phase,
   input logic              fill_phase,
   input logic [1:0]        vdirty
);
   AST_EVICT_DIRTY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      evict_phase && mem_valid |-> vdirty[mem_addr[2]]); // R3

   AST_FILL_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      fill_phase && mem_valid && mem_ready && mem_addr[2:0] != 3'd7
      |=> mem_addr[2:0] == $past(mem_addr[2:0]) + 3'd1); // R6

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready
      |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)); // R9

   AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_valid); // R2

   AST_RSP_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !busy); // R6
endmodule

bind cache_line_engine cle_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid),
   .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .evict_phase(state_q == cle_pkg::ST_EVICT),
   .fill_phase(state_q == cle_pkg::ST_FILL), .vdirty(r_vdirty)
);

// File: tb/sim_cache_line_engine.sv
module sim_cache_line_engine;
   localparam int  WAYS     = 4;
   localparam int  SETS     = 8;
   localparam int  ADDR_W   = 12;
   localparam int  DATA_W   = 32;
   localparam time CLK_HALF = 5ns;

   typedef struct packed {
      logic        wr;
      logic        cach;
      logic        wt;
      logic [1:0]  way;
      logic [11:0] addr;
      logic [31:0] wdata;
      logic [31:0] exp_rd;
      logic [3:0]  exp_wr;
      logic [3:0]  exp_rn;
   } vec_t;

   // Word address = {tag[11:6], set[5:3], word[2:0]}; memory starts as A000_0000 | addr
   localparam vec_t TBL [10] = '{
      '{1'b0,1'b1,1'b0,2'd0,12'h053,32'h0,         32'hA0000053,4'd0,4'd8}, // R6 miss fill
      '{1'b0,1'b1,1'b0,2'd0,12'h055,32'h0,         32'hA0000055,4'd0,4'd0}, // R2 hit
      '{1'b1,1'b1,1'b0,2'd0,12'h051,32'h11111111,  32'h0,       4'd0,4'd0}, // R4 wb store hit
      '{1'b0,1'b1,1'b0,2'd0,12'h051,32'h0,         32'h11111111,4'd0,4'd0}, // R4 updated word
      '{1'b1,1'b1,1'b1,2'd0,12'h056,32'h22222222,  32'h0,       4'd1,4'd0}, // R5 wt store hit
      '{1'b0,1'b1,1'b0,2'd0,12'h090,32'h0,         32'hA0000090,4'd4,4'd8}, // R3 half 0 only
      '{1'b1,1'b0,1'b0,2'd0,12'h200,32'h33333333,  32'h0,       4'd1,4'd0}, // R7 uncached store
      '{1'b0,1'b0,1'b0,2'd0,12'h200,32'h0,         32'h33333333,4'd0,4'd1}, // R7 uncached load
      '{1'b1,1'b1,1'b0,2'd0,12'h300,32'h44444444,  32'h0,       4'd1,4'd0}, // R8 store miss
      '{1'b0,1'b1,1'b0,2'd1,12'h300,32'h0,         32'h44444444,4'd0,4'd8}  // R8 no allocation
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0, req_ready, req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              req_cacheable = 1'b0, req_wthru = 1'b0;
   logic [1:0]        victim_way = '0;
   logic              rsp_valid, busy, mem_valid, mem_write;
   logic [DATA_W-1:0] rsp_rdata, mem_wdata, mem_rdata;
   logic [ADDR_W-1:0] mem_addr;
   logic              mem_ready = 1'b0;

   logic [DATA_W-1:0] memory [1 << ADDR_W];
   int                wr_count = 0, rd_count = 0;
   int                checks = 0, errors = 0;

   always #CLK_HALF clk = ~clk;

   cache_line_engine #(.WAYS(WAYS), .SETS(SETS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_cacheable(req_cacheable), .req_wthru(req_wthru), .victim_way(victim_way),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
   );

   assign mem_rdata = memory[mem_addr];

   initial for (int a = 0; a < (1 << ADDR_W); a++) memory[a] = 32'hA0000000 | a;

   always @(negedge clk) mem_ready <= rst_n ? ~mem_ready : 1'b0;

   always @(posedge clk) begin
      if (mem_valid && mem_ready) begin
         if (mem_write) begin
            memory[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
         end else begin
            rd_count <= rd_count + 1;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic cach, input logic wt,
                         input logic [1:0] way, input logic [11:0] addr,
                         input logic [31:0] wd, output logic [31:0] rd,
                         output int nwr, output int nrd);
      int w0, r0;
      w0 = wr_count;
      r0 = rd_count;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_cacheable = cach; req_wthru = wt;
      victim_way = way; req_addr = addr; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      if (!wr) begin
         while (!rsp_valid) @(negedge clk);
         rd = rsp_rdata;
      end else begin
         while (busy) @(negedge clk);
         rd = '0;
      end
      nwr = wr_count - w0;
      nrd = rd_count - r0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      int nw, nr;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 req_ready", 32'(req_ready), 32'd1);
      check("R1 busy", 32'(busy), 32'd0);
      check("R1 mem_valid", 32'(mem_valid), 32'd0);
      check("R1 rsp_valid", 32'(rsp_valid), 32'd0);

      foreach (TBL[i]) begin
         access(TBL[i].wr, TBL[i].cach, TBL[i].wt, TBL[i].way, TBL[i].addr,
                TBL[i].wdata, rd, nw, nr);
         if (!TBL[i].wr) check($sformatf("R2/R6/R7 row %0d data", i), rd, TBL[i].exp_rd);
         check($sformatf("R3/R5/R8 row %0d writes", i), 32'(nw), 32'(TBL[i].exp_wr));
         check($sformatf("R1/R6 row %0d reads", i), 32'(nr), 32'(TBL[i].exp_rn));
      end
      check("R3 dirty half written back", memory[12'h051], 32'h11111111);
      check("R5 write-through word in memory", memory[12'h056], 32'h22222222);

      // R3: both halves dirty, way 0 set 2 now holds tag 2
      access(1'b1, 1'b1, 1'b0, 2'd0, 12'h091, 32'h66666666, rd, nw, nr);
      check("R4 store hit no mem write", 32'(nw), 32'd0);
      access(1'b1, 1'b1, 1'b0, 2'd0, 12'h095, 32'h77777777, rd, nw, nr);
      access(1'b0, 1'b1, 1'b0, 2'd0, 12'h0D0, 32'h0, rd, nw, nr);
      check("R3 both halves written", 32'(nw), 32'd8);
      check("R3 half 1 word", memory[12'h095], 32'h77777777);
      check("R3 half 0 word", memory[12'h091], 32'h66666666);

      // R10: victim never filled
      access(1'b0, 1'b1, 1'b0, 2'd3, 12'h3F8, 32'h0, rd, nw, nr);
      check("R10 invalid victim no write-back", 32'(nw), 32'd0);
      // R10: clean victim (fresh line in way 3 set 7) replaced
      access(1'b0, 1'b1, 1'b0, 2'd3, 12'h7FA, 32'h0, rd, nw, nr);
      check("R10 clean victim no write-back", 32'(nw), 32'd0);
      check("R6 requested word 2", rd, 32'hA00007FA);

      // R7: uncached load of a cached, modified word bypasses the line
      access(1'b1, 1'b1, 1'b0, 2'd0, 12'h7FF, 32'h55555555, rd, nw, nr);
      access(1'b0, 1'b0, 1'b0, 2'd0, 12'h7FF, 32'h0, rd, nw, nr);
      check("R7 uncached load from memory", rd, 32'hA00007FF);
      access(1'b0, 1'b1, 1'b0, 2'd0, 12'h7FF, 32'h0, rd, nw, nr);
      check("R7 cached copy unchanged", rd, 32'h55555555);
      check("R2 hit no memory read", 32'(nr), 32'd0);

      // R9: busy during a fill
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_cacheable = 1'b1; req_wthru = 1'b0;
      victim_way = 2'd2; req_addr = 12'h123;
      @(negedge clk);
      req_valid = 1'b0;
      check("R9 busy during fill", 32'(busy), 32'd1);
      check("R9 ready low during fill", 32'(req_ready), 32'd0);
      while (!rsp_valid) @(negedge clk);
      check("R6 fill word 3", rsp_rdata, 32'hA0000123);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule